// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects up to 64 level-sensitive interrupt inputs and presents the processor with one request line plus a single status word. The status word names the winning source and its priority. Software gives every source a 4-bit priority. A source is switched on or off by writing its number, not a bit mask, to one of two command registers. A 4-bit threshold register holds back every request whose priority does not exceed it. An interrupt handler can therefore read the threshold, raise it to the level it is serving, and put it back afterwards.

Arbitration is combinational from the registered configuration and the live inputs. The status word always describes the current best candidate. When no source qualifies, the status read returns all ones, which is negative as a signed word. A simple 32-bit register bus with separate read and write strobes gives access. Read data is captured one clock after the read strobe.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset all sources are disabled, every priority field and the threshold read as 0, the status word reads 0xFFFFFFFF and `irq_o` is low.
- R2: Writing a source number (0..63) to offset 0x08 enables that source only; sources that were never enabled never win.
- R3: Writing a source number to offset 0x0C disables that source only; other enabled sources keep winning.
- R4: Priority register for source group g (sources 8g..8g+7) sits at offset 0x3C - 4g; source s occupies bits [(s%8)*4+3:(s%8)*4]; the registers read back what was written.
- R5: Reading offset 0x40 returns the winning source number in bits [31:16] and its priority in bits [15:0]; the winner is the qualifying source with the highest priority.
- R6: Among qualifying sources of equal priority, the higher source number wins.
- R7: A source qualifies only if its priority is strictly greater than the threshold held at offset 0x04 (bits [3:0], readable); with threshold 0, priority-0 sources never qualify.
- R8: Inputs are level-sensitive: a source stops competing in the cycle its input drops.
- R9: With no qualifying source the status word is 0xFFFFFFFF and `irq_o` is low; `irq_o` is high exactly when a source qualifies.
- R10: A number written to 0x08 or 0x0C with any bit above bit 5 set is ignored, and writes to the status offset 0x40 have no effect.
- R11: `rdata_o` updates on the clock edge that samples `rd_en_i` and holds its value while no read is strobed; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| src_i | input | 64 | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case is several sources qualifying at once while only priority, tie order and threshold decide the winner. Reaching it needs enables, priorities spread over several priority registers and a threshold, all set up through the bus before the inputs are driven. The bench first builds one fixed configuration with a deliberate priority tie, a priority-0 source and a never-enabled source. It then walks a table of input patterns against it. Directed steps then move the threshold up to and past the tied level, drop and restore sources one at a time, and send malformed numbers to the command registers.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

   // register offsets (byte addresses)
   localparam logic [7:0] OFF_MASK     = 8'h04;
   localparam logic [7:0] OFF_ENNUM    = 8'h08;
   localparam logic [7:0] OFF_DISNUM   = 8'h0C;
   localparam logic [7:0] OFF_PRIO_TOP = 8'h3C;  // group 0, others step downward
   localparam logic [7:0] OFF_STAT     = 8'h40;

   // decoded kind of register access
   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_MASK,
      ACC_EN,
      ACC_DIS,
      ACC_PRIO,
      ACC_STAT
   } acc_e;

endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
   import vpic_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic                      rd_en_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic [DATA_W-1:0]         stat_i,
   output logic [NUM_SRC-1:0]        en_o,
   output logic [NUM_SRC*PRIO_W-1:0] prio_o,
   output logic [PRIO_W-1:0]         mask_o,
   output logic [DATA_W-1:0]         rdata_o
);

   localparam int SRC_W    = $clog2(NUM_SRC);
   localparam int PER_REG  = DATA_W / PRIO_W;
   localparam int NUM_PREG = NUM_SRC / PER_REG;
   localparam int GRP_W    = (NUM_PREG > 1) ? $clog2(NUM_PREG) : 1;

   // elaboration-time parameter checks
   if (PRIO_W * PER_REG != DATA_W) begin : g_bad_prio_w
      $error("vpic_regs: PRIO_W must divide DATA_W");
   end
   if (NUM_PREG * PER_REG != NUM_SRC) begin : g_bad_num_src
      $error("vpic_regs: NUM_SRC must be a multiple of DATA_W/PRIO_W");
   end
   if (ADDR_W != 8) begin : g_bad_addr_w
      $error("vpic_regs: offsets are defined for an 8-bit address");
   end
   if (int'(OFF_PRIO_TOP) - 4 * (NUM_PREG - 1) <= int'(OFF_DISNUM)) begin : g_bad_map
      $error("vpic_regs: priority registers overlap the command registers");
   end

   // ---------------- decode ----------------
   acc_e             acc_kind;
   logic [GRP_W-1:0] acc_grp;

   always_comb begin
      acc_kind = ACC_NONE;
      acc_grp  = '0;
      case (addr_i)
         OFF_MASK:   acc_kind = ACC_MASK;
         OFF_ENNUM:  acc_kind = ACC_EN;
         OFF_DISNUM: acc_kind = ACC_DIS;
         OFF_STAT:   acc_kind = ACC_STAT;
         default: begin
            for (int g = 0; g < NUM_PREG; g++) begin
               if (addr_i == OFF_PRIO_TOP - ADDR_W'(4 * g)) begin
                  acc_kind = ACC_PRIO;
                  acc_grp  = GRP_W'(g);
               end
            end
         end
      endcase
   end

   // source number carried in a command write
   logic [SRC_W-1:0] num;
   logic             num_ok;

   assign num    = wdata_i[SRC_W-1:0];
   assign num_ok = (wdata_i[DATA_W-1:SRC_W] == '0) && (int'(num) < NUM_SRC);

   // ---------------- enables ----------------
   logic [NUM_SRC-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en_i && num_ok) begin
         if (acc_kind == ACC_EN)  en_q[num] <= 1'b1;
         if (acc_kind == ACC_DIS) en_q[num] <= 1'b0;
      end
   end

   // ---------------- threshold ----------------
   logic [PRIO_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_en_i && acc_kind == ACC_MASK) begin
         mask_q <= wdata_i[PRIO_W-1:0];
      end
   end

   // ---------------- priorities ----------------
   logic [NUM_SRC*PRIO_W-1:0] prio_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
      localparam int GRP  = s / PER_REG;
      localparam int SLOT = s % PER_REG;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prio_q[s*PRIO_W +: PRIO_W] <= '0;
         end else if (wr_en_i && acc_kind == ACC_PRIO && acc_grp == GRP_W'(GRP)) begin
            prio_q[s*PRIO_W +: PRIO_W] <= wdata_i[SLOT*PRIO_W +: PRIO_W];
         end
      end
   end

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      case (acc_kind)
         ACC_MASK: rd_val[PRIO_W-1:0] = mask_q;
         ACC_STAT: rd_val = stat_i;
         ACC_PRIO: begin
            for (int k = 0; k < PER_REG; k++) begin
               rd_val[k*PRIO_W +: PRIO_W] =
                  prio_q[(int'(acc_grp) * PER_REG + k) * PRIO_W +: PRIO_W];
            end
         end
         default: rd_val = '0;
      endcase
   end

   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en_i) begin
         rdata_q <= rd_val;
      end
   end

   assign en_o    = en_q;
   assign prio_o  = prio_q;
   assign mask_o  = mask_q;
   assign rdata_o = rdata_q;

   // ---------------- assertions ----------------
   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == OFF_ENNUM && wdata_i < DATA_W'(NUM_SRC))
      |=> en_q[$past(wdata_i[SRC_W-1:0])]);

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == OFF_DISNUM && wdata_i < DATA_W'(NUM_SRC))
      |=> !en_q[$past(wdata_i[SRC_W-1:0])]);

   // R10
   bad_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (addr_i == OFF_ENNUM || addr_i == OFF_DISNUM)
       && wdata_i >= DATA_W'(NUM_SRC))
      |=> $stable(en_q));

   // R7
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && addr_i == OFF_MASK) |=> $stable(mask_q));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
   parameter int NUM_SRC  = 64,
   parameter int PRIO_W   = 4,
   parameter bit TIE_HIGH = 1'b1,   // 1: higher source number wins a tie
   localparam int SRC_W   = $clog2(NUM_SRC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        req_i,
   input  logic [NUM_SRC-1:0]        en_i,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         mask_i,
   output logic                      vld_o,
   output logic [SRC_W-1:0]          idx_o,
   output logic [PRIO_W-1:0]         prio_o
);

   if (NUM_SRC < 2) begin : g_bad_num
      $error("vpic_arb: NUM_SRC must be at least 2");
   end

   // a source competes when asserted, enabled and above the threshold
   logic [NUM_SRC-1:0] qual;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
      assign qual[s] = req_i[s] && en_i[s] && (prio_i[s*PRIO_W +: PRIO_W] > mask_i);
   end

   logic              best_vld;
   logic [SRC_W-1:0]  best_idx;
   logic [PRIO_W-1:0] best_pr;

   if (TIE_HIGH) begin : g_tie_high
      always_comb begin
         best_vld = 1'b0;
         best_idx = '0;
         best_pr  = '0;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (qual[s] && (!best_vld || prio_i[s*PRIO_W +: PRIO_W] >= best_pr)) begin
               best_vld = 1'b1;
               best_idx = SRC_W'(s);
               best_pr  = prio_i[s*PRIO_W +: PRIO_W];
            end
         end
      end
   end else begin : g_tie_low
      always_comb begin
         best_vld = 1'b0;
         best_idx = '0;
         best_pr  = '0;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (qual[s] && (!best_vld || prio_i[s*PRIO_W +: PRIO_W] > best_pr)) begin
               best_vld = 1'b1;
               best_idx = SRC_W'(s);
               best_pr  = prio_i[s*PRIO_W +: PRIO_W];
            end
         end
      end
   end

   assign vld_o  = best_vld;
   assign idx_o  = best_idx;
   assign prio_o = best_pr;

   // ---------------- assertions ----------------
   // R7
   above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (prio_o > mask_i));

   // R8
   winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (req_i[idx_o] && en_i[idx_o]));

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_i & en_i) == '0) |-> !vld_o);

endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
   import vpic_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NUM_SRC-1:0] src_i,
   output logic              irq_o
);

   localparam int SRC_W  = $clog2(NUM_SRC);
   localparam int HALF_W = DATA_W / 2;

   if (SRC_W > HALF_W - 1 || PRIO_W > HALF_W) begin : g_bad_stat
      $error("vpic_ctrl: status halves too narrow for source number or priority");
   end

   logic [NUM_SRC-1:0]        en;
   logic [NUM_SRC*PRIO_W-1:0] prio;
   logic [PRIO_W-1:0]         mask;
   logic                      win_vld;
   logic [SRC_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_pr;
   logic [DATA_W-1:0]         stat;

   vpic_regs #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .stat_i  (stat),
      .en_o    (en),
      .prio_o  (prio),
      .mask_o  (mask),
      .rdata_o (rdata_o)
   );

   vpic_arb #(
      .NUM_SRC  (NUM_SRC),
      .PRIO_W   (PRIO_W),
      .TIE_HIGH (1'b1)
   ) arb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (src_i),
      .en_i   (en),
      .prio_i (prio),
      .mask_i (mask),
      .vld_o  (win_vld),
      .idx_o  (win_idx),
      .prio_o (win_pr)
   );

   // status word: number high, priority low, all ones when idle
   assign stat  = win_vld ? {HALF_W'(win_idx), HALF_W'(win_pr)} : '1;
   assign irq_o = win_vld;

   // R9
   irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (src_i != '0));

endmodule

// File: tb/vpic_ctrl_tb_top.sv
module vpic_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] NONE = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] src = '0;
   logic        irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vpic_ctrl dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en),
      .rd_en_i (rd_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .src_i   (src),
      .irq_o   (irq)
   );

   // configuration used by the table: enabled 3,5,10,20,40,63
   // priorities 3:5 5:0 10:9 20:9 40:12 63:2, threshold 0
   // entry = {inputs, expected status}
   localparam logic [95:0] VEC [0:8] = '{
      {64'h0,                   NONE},           // R9 idle
      {64'h8,                   32'h0003_0005},  // R5 single
      {64'h408,                 32'h000A_0009},  // R5 higher priority wins
      {64'h0010_0400,           32'h0014_0009},  // R6 tie -> 20
      {64'h0000_0100_0000_0008, 32'h0028_000C},  // R5
      {64'h8000_0000_0000_0000, 32'h003F_0002},  // R5 top source
      {64'h20,                  NONE},           // R7 priority 0 vs threshold 0
      {64'h80,                  NONE},           // R2 never enabled
      {64'hFFFF_FFFF_FFFF_FFFF, 32'h0028_000C}   // R5 all asserted
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic stat_is(input string req, input logic [63:0] s, input logic [31:0] exp);
      logic [31:0] v;
      @(negedge clk);
      src = s;
      #1;
      check(req, {31'b0, irq}, {31'b0, exp != NONE});
      bus_rd(8'h40, v);
      check(req, v, exp);
   endtask

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(8'h04, v); check("R1", v, 32'h0);
      bus_rd(8'h3C, v); check("R1", v, 32'h0);
      bus_rd(8'h20, v); check("R1", v, 32'h0);
      src = '1;
      #1 check("R1", {31'b0, irq}, 32'h0);
      bus_rd(8'h40, v); check("R1", v, NONE);
      src = '0;

      // configuration
      bus_wr(8'h3C, 32'h0000_5000);   // group 0: src3=5, src5=0
      bus_wr(8'h38, 32'h0000_0900);   // group 1: src10=9
      bus_wr(8'h34, 32'h0009_0000);   // group 2: src20=9
      bus_wr(8'h28, 32'h0000_000C);   // group 5: src40=12
      bus_wr(8'h20, 32'h2000_0000);   // group 7: src63=2
      bus_wr(8'h08, 32'd3);
      bus_wr(8'h08, 32'd5);
      bus_wr(8'h08, 32'd10);
      bus_wr(8'h08, 32'd20);
      bus_wr(8'h08, 32'd40);
      bus_wr(8'h08, 32'd63);

      // R4 priority readback at descending offsets
      bus_rd(8'h3C, v); check("R4", v, 32'h0000_5000);
      bus_rd(8'h38, v); check("R4", v, 32'h0000_0900);
      bus_rd(8'h28, v); check("R4", v, 32'h0000_000C);
      bus_rd(8'h20, v); check("R4", v, 32'h2000_0000);

      // table walk
      for (int i = 0; i < 9; i++) begin
         stat_is("R5/R6/R7/R9 table", VEC[i][95:32], VEC[i][31:0]);
      end

      // R7 threshold
      bus_wr(8'h04, 32'h9);
      bus_rd(8'h04, v); check("R7", v, 32'h9);
      stat_is("R7", 64'h0000_0100_0000_0408, 32'h0028_000C);
      stat_is("R7", 64'h0000_0000_0010_0408, NONE);
      bus_wr(8'h04, 32'h8);
      stat_is("R7", 64'h0000_0000_0010_0408, 32'h0014_0009);
      bus_wr(8'h04, 32'h0);

      // R8 level sensitivity
      stat_is("R8", 64'h0000_0100_0000_0008, 32'h0028_000C);
      stat_is("R8", 64'h0000_0000_0000_0008, 32'h0003_0005);

      // R3 disable only the named source
      bus_wr(8'h0C, 32'd40);
      stat_is("R3", 64'h0000_0100_0000_0008, 32'h0003_0005);
      stat_is("R3", 64'h8000_0000_0000_0000, 32'h003F_0002);

      // R10 oversized number and status writes ignored
      bus_wr(8'h08, 32'h47);
      stat_is("R10", 64'h80, NONE);
      bus_wr(8'h0C, 32'h0000_0143);
      stat_is("R10", 64'h8, 32'h0003_0005);
      bus_wr(8'h40, 32'h0);
      stat_is("R10", 64'h8, 32'h0003_0005);

      // R2 enable a new source
      bus_wr(8'h08, 32'd7);
      bus_wr(8'h3C, 32'h7000_5000);
      stat_is("R2", 64'h88, 32'h0007_0007);

      // R11 hold between reads, unmapped reads 0
      bus_rd(8'h38, v);
      repeat (3) @(negedge clk);
      check("R11", rdata, 32'h0000_0900);
      bus_rd(8'h10, v); check("R11", v, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule